// File: doc/BRIEF.md
# Serial Debug Port Instruction Stuffer

This block is the target side of a serial debug link for a processor core. A host sends framed transactions on a single serial input line, timed by the debug clock. Each transaction carries either a 32-bit payload or a 7-bit payload. A 32-bit payload is a raw opcode. While the core is in debug mode, the port hands the opcode to the core for execution. When the core reports completion, the port captures the core's debug data word and returns it to the host. A 7-bit payload does not reach the core. It rewrites a small set of breakpoint and debug control bits, one of which enables single-stepping.

There is no command decoding. Everything the host wants done is expressed as opcodes that the core executes. Debug mode begins when the core signals an exception-type event. It ends when the core completes the resume opcode. While a stuffed opcode is still executing, the status output stays high and new frames are refused. A refused attempt is remembered and reported to the host.

Results travel back on the serial output while the next frame is being shifted in. The host therefore always reads the outcome of the previous transaction.

Top module: `dbgport_top`

## Requirements
- R1: After reset, serOut, status, stuffValid and inDebug are low and ctrlBits is zero.
- R2: While idle, the port waits for a 1 on serIn, sampled on a rising clock edge; this is the start bit. The next three fields follow in order: a kind bit (0 = opcode frame, 1 = control frame), then a size bit (0 = 32-bit payload, 1 = 7-bit payload), then the payload, most significant bit first.
- R3: An opcode frame with a 32-bit payload, received in debug mode, places the payload on insn. In the cycle after the last payload bit, stuffValid is high for exactly one cycle. From that cycle, status stays high until the clock edge at which coreDone is sampled high.
- R4: At the clock edge that ends status, coreData is captured as the return data.
- R5: At each accepted start bit the port snapshots a 33-bit return word: first the busy-error flag, then the 32-bit return data, most significant bit first. serOut changes on falling edges. The host reads the flag at the rising edge of the kind bit and one further bit at each later rising edge. A 7-bit frame therefore carries only the first 9 bits. serOut is low while idle.
- R6: An opcode frame with a 32-bit payload, received outside debug mode, produces no stuffValid pulse and leaves status low. It sets the return data to all ones.
- R7: A control frame with a 7-bit payload writes the payload to ctrlBits, whose bit 0 is the single-step enable. It sets the return data to the payload zero-extended.
- R8: The two remaining combinations are dropped. These are a control frame with a 32-bit payload and an opcode frame with a 7-bit payload. Neither changes ctrlBits, the return data or the core interface.
- R9: When coreExc is sampled high, inDebug is high from the next cycle.
- R10: If the completing opcode is 0x4C000064, inDebug falls at the clock edge where coreDone is sampled. Later opcode frames are then discarded as in R6.
- R11: A start bit that arrives while status is high is ignored and sets a sticky busy-error flag. The next accepted frame reports the flag as the first return bit, and the flag is cleared once reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serIn | input | 1 | Serial frame input, sampled on rising edges |
| serOut | output | 1 | Serial return output, updated on falling edges |
| status | output | 1 | High while a stuffed opcode is executing |
| coreExc | input | 1 | Exception event from the core; enters debug mode |
| insn | output | 32 | Opcode presented to the core |
| stuffValid | output | 1 | One-cycle strobe: insn is ready to execute |
| coreDone | input | 1 | Core has completed the stuffed opcode |
| coreData | input | 32 | Debug data word from the core, captured on completion |
| inDebug | output | 1 | Debug mode active |
| ctrlBits | output | 7 | Breakpoint and debug control bits; bit 0 enables single-step |

## Verification
The embedded assertions check several properties on every cycle. They confirm that status only rises in debug mode and holds until completion. They confirm that stuffValid is a single-cycle pulse and that ctrlBits changes only on a control-frame strobe. They also confirm that a start bit arriving while busy leaves the frame machine idle and that debug mode is left only through a completed resume opcode. Other behaviour can only be shown by the bench's scenarios, which compare what the host sees against values computed independently. This covers the bit order of the returned word, its one-transaction delay, the all-ones word after a discarded opcode, and the control value read back for each of the 128 control values. It also covers the dropped mismatched frames and the busy-error flag appearing once and then clearing.

// File: rtl/dbgport_pkg.sv
`timescale 1ns/1ps
package dbgport_pkg;
  // strobes from the frame controller to the datapath
  typedef struct packed {
    logic loadOut;   // snapshot return word at accepted start bit
    logic shiftOut;  // advance return shifter
    logic shiftIn;   // shift a payload bit in
    logic stuff;     // hand frame word to the core
    logic ctrlWr;    // update control bits
    logic discard;   // opcode rejected outside debug mode
    logic capture;   // core completed: take its data word
  } strobes_t;
endpackage

// File: rtl/dbgport_ctrl.sv
`timescale 1ns/1ps
module dbgport_ctrl
  import dbgport_pkg::*;
#(
  parameter int LONG_W  = 32,
  parameter int SHORT_W = 7
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serIn,
  input  logic     coreDone,
  input  logic     coreExc,
  input  logic     isResume,
  output strobes_t strb,
  output logic     frameActive,
  output logic     busy,
  output logic     inDebug,
  output logic     busyErr
);
  localparam int CNT_W = $clog2(LONG_W);

  typedef enum logic [1:0] {S_IDLE, S_KIND, S_SIZE, S_PAY} state_t;

  state_t            state;
  logic              kindQ;
  logic              shortQ;
  logic [CNT_W-1:0]  cnt;
  logic              lastBit;
  logic              startOk;

  always_comb begin
    lastBit       = (state == S_PAY) && (cnt == '0);
    startOk       = (state == S_IDLE) && serIn && !busy;
    strb          = '0;
    strb.loadOut  = startOk;
    strb.shiftOut = (state != S_IDLE);
    strb.shiftIn  = (state == S_PAY);
    strb.stuff    = lastBit && !shortQ && !kindQ && inDebug;
    strb.discard  = lastBit && !shortQ && !kindQ && !inDebug;
    strb.ctrlWr   = lastBit && shortQ && kindQ;
    strb.capture  = coreDone && busy;
  end

  assign frameActive = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      kindQ  <= 1'b0;
      shortQ <= 1'b0;
      cnt    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (startOk) state <= S_KIND;
        S_KIND: begin
          kindQ <= serIn;
          state <= S_SIZE;
        end
        S_SIZE: begin
          shortQ <= serIn;
          cnt    <= serIn ? CNT_W'(SHORT_W - 1) : CNT_W'(LONG_W - 1);
          state  <= S_PAY;
        end
        S_PAY: begin
          cnt <= cnt - 1'b1;
          if (lastBit) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      inDebug <= 1'b0;
      busyErr <= 1'b0;
    end else begin
      if (strb.stuff) busy <= 1'b1;
      else if (strb.capture) busy <= 1'b0;

      if (coreExc) inDebug <= 1'b1;
      else if (strb.capture && isResume) inDebug <= 1'b0;

      if ((state == S_IDLE) && serIn && busy) busyErr <= 1'b1;
      else if (startOk) busyErr <= 1'b0;
    end
  end

  // R11: a start bit seen while busy leaves the frame machine idle
  assert_start_blocked_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_IDLE) && serIn && busy) |=> (state == S_IDLE));

  // R3: status holds until the core reports completion
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !coreDone) |=> busy);

  // R6: execution only starts in debug mode
  assert_stuff_in_debug_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(inDebug));

  // R10: debug mode is left only by a completed resume opcode
  assert_exit_resume_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inDebug) |-> $past(coreDone && busy && isResume));
endmodule

// File: rtl/dbgport_data.sv
`timescale 1ns/1ps
module dbgport_data
  import dbgport_pkg::*;
#(
  parameter int          LONG_W     = 32,
  parameter int          SHORT_W    = 7,
  parameter logic [31:0] RESUME_OP  = 32'h4C00_0064
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIn,
  input  strobes_t           strb,
  input  logic               frameActive,
  input  logic               busyErr,
  input  logic [LONG_W-1:0]  coreData,
  output logic               serOut,
  output logic [LONG_W-1:0]  insn,
  output logic               stuffValid,
  output logic [SHORT_W-1:0] ctrlBits,
  output logic               isResume
);
  localparam int RET_W = LONG_W + 1;

  logic [LONG_W-2:0] inSr;
  logic [LONG_W-1:0] frameWord;
  logic [LONG_W-1:0] retData;
  logic [RET_W-1:0]  outSr;

  assign frameWord = {inSr, serIn};
  assign isResume  = (insn == LONG_W'(RESUME_OP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSr       <= '0;
      outSr      <= '0;
      insn       <= '0;
      stuffValid <= 1'b0;
      ctrlBits   <= '0;
      retData    <= '0;
    end else begin
      if (strb.shiftIn) inSr <= frameWord[LONG_W-2:0];

      if (strb.loadOut) outSr <= {busyErr, retData};
      else if (strb.shiftOut) outSr <= {outSr[RET_W-2:0], 1'b0};

      if (strb.stuff) insn <= frameWord;
      stuffValid <= strb.stuff;

      if (strb.ctrlWr) begin
        ctrlBits <= frameWord[SHORT_W-1:0];
        retData  <= LONG_W'(frameWord[SHORT_W-1:0]);
      end else if (strb.discard) begin
        retData <= '1;
      end else if (strb.capture) begin
        retData <= coreData;
      end
    end
  end

  // return bits change on the falling edge, half a cycle ahead of host sampling
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) serOut <= 1'b0;
    else       serOut <= frameActive ? outSr[RET_W-1] : 1'b0;
  end

  // R3: the execute strobe lasts a single cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    stuffValid |=> !stuffValid);

  // R7: control bits move only on a control-frame strobe
  assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlBits) |-> $past(strb.ctrlWr));
endmodule

// File: rtl/dbgport_top.sv
`timescale 1ns/1ps
module dbgport_top
  import dbgport_pkg::*;
#(
  parameter int          LONG_W    = 32,
  parameter int          SHORT_W   = 7,
  parameter logic [31:0] RESUME_OP = 32'h4C00_0064
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIn,
  output logic               serOut,
  output logic               status,
  input  logic               coreExc,
  output logic [LONG_W-1:0]  insn,
  output logic               stuffValid,
  input  logic               coreDone,
  input  logic [LONG_W-1:0]  coreData,
  output logic               inDebug,
  output logic [SHORT_W-1:0] ctrlBits
);
  strobes_t strb;
  logic     frameActive;
  logic     busyErr;
  logic     isResume;

  dbgport_ctrl #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .serIn(serIn), .coreDone(coreDone),
    .coreExc(coreExc), .isResume(isResume), .strb(strb),
    .frameActive(frameActive), .busy(status), .inDebug(inDebug),
    .busyErr(busyErr)
  );

  dbgport_data #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .RESUME_OP(RESUME_OP)) uData (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strb(strb),
    .frameActive(frameActive), .busyErr(busyErr), .coreData(coreData),
    .serOut(serOut), .insn(insn), .stuffValid(stuffValid),
    .ctrlBits(ctrlBits), .isResume(isResume)
  );
endmodule

// File: tb/tb_dbgport_top.sv
`timescale 1ns/1ps
module tb_dbgport_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serIn = 1'b0;
  logic        coreExc = 1'b0;
  logic        coreDone = 1'b0;
  logic [31:0] coreData = '0;
  logic        serOut, status, stuffValid, inDebug;
  logic [31:0] insn;
  logic [6:0]  ctrlBits;

  int errs = 0;
  int checks = 0;
  int pulses = 0;
  bit done = 0;

  localparam logic [31:0] RESUME = 32'h4C00_0064;

  dbgport_top dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .serOut(serOut), .status(status),
    .coreExc(coreExc), .insn(insn), .stuffValid(stuffValid),
    .coreDone(coreDone), .coreData(coreData), .inDebug(inDebug),
    .ctrlBits(ctrlBits)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (stuffValid) pulses++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // start, kind, size, payload MSB first; collects the 33-bit return word
  task automatic sendFrame(input bit kind, input bit isShort, input logic [31:0] pay,
                           output logic [32:0] ret);
    int n;
    n = isShort ? 10 : 35;
    ret = '0;
    for (int k = 0; k < n; k++) begin
      bit b;
      if (k == 0) b = 1'b1;
      else if (k == 1) b = kind;
      else if (k == 2) b = isShort;
      else b = pay[n - 1 - k];
      @(negedge clk); #1 serIn = b; #3;
      if (k >= 1 && k <= 33) ret[33 - k] = serOut;
    end
    @(negedge clk); #1 serIn = 1'b0;
  endtask

  task automatic coreFinish(input int delay, input logic [31:0] d);
    repeat (delay) @(negedge clk);
    #1 coreDone = 1'b1; coreData = d;
    @(negedge clk); #1 coreDone = 1'b0;
  endtask

  function automatic logic [31:0] dataFor(input logic [31:0] op);
    return {op[15:0], op[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  initial begin
    logic [32:0] r;
    logic [31:0] lastData;
    logic [31:0] op;

    repeat (3) @(negedge clk);
    #1;
    chk(serOut == 0 && status == 0 && stuffValid == 0 && inDebug == 0, "R1 outputs",
        {serOut, status, stuffValid, inDebug}, 0);
    chk(ctrlBits == 0, "R1 ctrlBits", ctrlBits, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk(serOut == 0, "R5 idle serOut", serOut, 0);

    // opcode outside debug mode is discarded
    sendFrame(0, 0, 32'h1234_5678, r);
    chk(stuffValid == 0 && status == 0, "R6 no stuff", {stuffValid, status}, 0);
    chk(r == 33'h0, "R5 first return", r, 0);
    sendFrame(0, 0, 32'h0, r);
    chk(r == {1'b0, 32'hFFFF_FFFF}, "R6 all ones", r, {1'b0, 32'hFFFF_FFFF});

    // sweep every control value; read it back through a discarded opcode frame
    for (int v = 0; v < 128; v++) begin
      sendFrame(1, 1, 32'(v), r);
      chk(r[32:24] == 9'h0FF, "R5 short frame return", r[32:24], 9'h0FF);
      chk(ctrlBits == 7'(v) && ctrlBits[0] == v[0], "R7 ctrlBits", ctrlBits, v);
      sendFrame(0, 0, 32'h0, r);
      chk(r == {1'b0, 32'(v)}, "R7 readback R2", r, {1'b0, 32'(v)});
    end

    // mismatched kind/size combinations are dropped
    sendFrame(1, 1, 32'h55, r);
    sendFrame(1, 0, 32'hDEAD_BEEF, r);
    sendFrame(0, 1, 32'h2A, r);
    chk(ctrlBits == 7'h55 && stuffValid == 0 && status == 0, "R8 no effect",
        {ctrlBits, stuffValid, status}, {7'h55, 2'b00});
    sendFrame(0, 0, 32'h0, r);
    chk(r == {1'b0, 32'h55}, "R8 return unchanged", r, {1'b0, 32'h55});
    chk(pulses == 0, "R6 pulse count", pulses, 0);

    // enter debug mode
    @(negedge clk); #1 coreExc = 1'b1;
    @(negedge clk); #1 coreExc = 1'b0;
    chk(inDebug == 1, "R9 debug entry", inDebug, 1);

    // stuff several opcodes with different completion delays
    lastData = '0;
    for (int i = 0; i < 8; i++) begin
      op = 32'h3860_0000 + 32'(i) * 32'h0103_0107;
      sendFrame(0, 0, op, r);
      chk(stuffValid == 1 && insn == op, "R3 stuff R2 order", {stuffValid, insn}, {1'b1, op});
      chk(status == 1, "R3 status high", status, 1);
      if (i > 0) chk(r == {1'b0, lastData}, "R4 returned data", r, {1'b0, lastData});
      @(negedge clk); #1;
      chk(stuffValid == 0 && status == 1, "R3 pulse width", {stuffValid, status}, 2'b01);
      lastData = dataFor(op);
      coreFinish(i, lastData);
      chk(status == 0 && inDebug == 1, "R4 completion", {status, inDebug}, 2'b01);
    end

    // start bit while busy is ignored and flagged
    op = 32'h7C00_02A6;
    sendFrame(0, 0, op, r);
    chk(r == {1'b0, lastData}, "R4 last data", r, {1'b0, lastData});
    @(negedge clk); #1 serIn = 1'b1;
    @(negedge clk); #1 serIn = 1'b0;
    chk(status == 1 && stuffValid == 0, "R11 start ignored", {status, stuffValid}, 2'b10);
    lastData = dataFor(op);
    coreFinish(2, lastData);
    sendFrame(0, 0, RESUME, r);
    chk(r == {1'b1, lastData}, "R11 flag reported", r, {1'b1, lastData});
    chk(insn == RESUME && stuffValid == 1, "R10 resume stuffed", insn, RESUME);
    lastData = 32'hC0DE_0001;
    coreFinish(1, lastData);
    chk(inDebug == 0 && status == 0, "R10 debug exit", {inDebug, status}, 0);
    sendFrame(0, 0, 32'h1111_2222, r);
    chk(r == {1'b0, lastData}, "R11 flag cleared", r, {1'b0, lastData});
    chk(stuffValid == 0 && status == 0, "R10 discard after exit", {stuffValid, status}, 0);
    sendFrame(0, 0, 32'h0, r);
    chk(r == {1'b0, 32'hFFFF_FFFF}, "R6 all ones again", r, {1'b0, 32'hFFFF_FFFF});
    chk(pulses == 10, "R3 total pulses", pulses, 10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule